// File: doc/BRIEF.md
# Interrupt Source Front End

This block is the per-source input stage of a platform interrupt controller. Every source, numbered from 1, has a configuration word, a pending flag and an enable flag. The block samples the raw interrupt wires and sets pending according to each source's trigger mode. It also exposes a 32-bit register window that software uses to program the configuration words and to set or clear the pending and enable flags. Those flags can be changed in bulk, 32 sources per word, or one source at a time by number.

Its output is one flag per source that is high when that source is both pending and enabled. A downstream selector consumes these flags and returns a claim, which clears the pending flag of the claimed source. A source can be handed to a child domain instead of being served locally. Its configuration word then carries a child index, and the source no longer takes part in pending or enable.

Top module: `isrc_frontend`

## Requirements
- R1: After reset, every configuration word, pending flag and enable flag reads 0, and `irq_pe` is all zeros.
- R2: The configuration word of source i is at byte offset 4*i. When bit 10 of the write is 0, bits [2:0] store the mode and read back with all other bits 0.
- R3: A mode write of the reserved codes 2 or 3 is stored as 0 (inactive). Bit 0 of bulk word 0 (source 0) and bits above the source count always read 0 and ignore writes.
- R4: A write with bit 10 set delegates the source and stores bits [9:0] as a child index; it reads back as 0x400 | index. A delegated or inactive source holds pending and enable at 0, and writes to them have no effect.
- R5: Mode 4 (rising) and mode 5 (falling) set pending on the matching wire transition, one cycle after the edge is sampled. Pending stays set after the wire returns, until software clears it or a claim arrives.
- R6: A claim of a source in edge or detached mode clears its pending flag. A new edge in the same cycle as a clear or claim leaves pending set.
- R7: In mode 6 (high) pending copies the wire, and in mode 7 (low) it copies the inverted wire, one cycle later. Software set and clear of pending have no effect in these modes.
- R8: In mode 1 (detached) the wire is ignored. Pending is set only through the set-pending registers and cleared through clear-pending or a claim.
- R9: The bulk registers are at 0x1C00+4k (set pending), 0x1D00+4k (clear pending), 0x1E00+4k (set enable) and 0x1F00+4k (clear enable). In word k, bit j is source 32k+j. Ones act and zeros have no effect. Reads return the pending flags at 0x1C00+4k, the enable flags at 0x1E00+4k, and 0 at the clear addresses.
- R10: The by-number registers at 0x1CDC (set pending), 0x1DDC (clear pending), 0x1EDC (set enable) and 0x1FDC (clear enable) take a source number in bits [9:0]. Number 0 or a number above the source count does nothing.
- R11: Bit i-1 of `src_in` is the wire of source i, and bit i-1 of `irq_pe` is pending AND enable of source i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Raw interrupt wires, bit i-1 for source i |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| claim_valid | input | 1 | Claim strobe from the downstream selector |
| claim_id | input | 10 | Number of the claimed source |
| irq_pe | output | NUM_SRC | Pending-and-enabled flag per source |

## Verification
A corrupted per-source state shows up at the ports one cycle after the stimulus that exposes it. The bulk pending or enable read word has the wrong bit, and the matching `irq_pe` bit is wrong too. A stale edge history shows as pending rising with no transition, or as a missed transition, on the cycle after the wire moves. A wrong configuration word shows as an immediate readback mismatch. It also shows as a mode behaving like a different trigger type on the next wire change. Claim and clear ordering errors show as a pending flag that stays set, or disappears, in the single cycle after the conflict.

// File: rtl/isrc_pkg.sv
package isrc_pkg;

  localparam int IDX_W   = 10;
  localparam int DEL_BIT = 10;

  typedef enum logic [2:0] {
    SM_OFF    = 3'd0,
    SM_DETACH = 3'd1,
    SM_RISE   = 3'd4,
    SM_FALL   = 3'd5,
    SM_HIGH   = 3'd6,
    SM_LOW    = 3'd7
  } smode_e;

  // order follows address bits [9:8] of the flag windows
  typedef enum logic [1:0] {
    OP_SETIP = 2'd0,
    OP_CLRIP = 2'd1,
    OP_SETIE = 2'd2,
    OP_CLRIE = 2'd3
  } bitop_e;

  typedef struct packed {
    logic             deleg;
    logic [IDX_W-1:0] payload;
  } cfg_t;

  // turn a software write into the stored form, dropping reserved modes
  function automatic cfg_t cfg_pack(input logic [31:0] w);
    cfg_t c;
    logic [2:0] m;
    m = w[2:0];
    if (w[DEL_BIT]) begin
      c.deleg   = 1'b1;
      c.payload = w[IDX_W-1:0];
    end else begin
      c.deleg   = 1'b0;
      c.payload = '0;
      if (m != 3'd2 && m != 3'd3) c.payload[2:0] = m;
    end
    return c;
  endfunction

  function automatic logic [31:0] cfg_view(input cfg_t c);
    logic [31:0] r;
    r = '0;
    if (c.deleg) begin
      r[DEL_BIT]     = 1'b1;
      r[IDX_W-1:0]   = c.payload;
    end else begin
      r[2:0] = c.payload[2:0];
    end
    return r;
  endfunction

  function automatic logic mode_is_edge(input logic [2:0] m);
    return m[2] & ~m[1];
  endfunction

  function automatic logic mode_is_level(input logic [2:0] m);
    return m[2] & m[1];
  endfunction

  function automatic logic mode_inverts(input logic [2:0] m);
    return m[2] & m[0];
  endfunction

endpackage

// File: rtl/isrc_addr_dec.sv
module isrc_addr_dec
  import isrc_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int NUM_SRC = 40,
  parameter int NWORDS  = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              cfg_hit_o,
  output logic [IDX_W-1:0]  cfg_idx_o,
  output logic              bulk_hit_o,
  output logic [4:0]        bulk_word_o,
  output logic              num_hit_o,
  output bitop_e            op_o
);
  localparam int                  IW       = ADDR_W - 2;
  localparam logic [IW-1:0]       LAST_SRC = IW'(NUM_SRC);
  localparam logic [ADDR_W-11:0]  FLAG_PG  = (ADDR_W-10)'(7);
  localparam logic [5:0]          NUM_SLOT = 6'h37;
  localparam logic [5:0]          WORDS    = 6'(NWORDS);

  logic [IW-1:0] word_addr;
  logic          aligned;
  logic          flag_page;
  logic [5:0]    slot;

  always_comb begin
    word_addr   = addr_i[ADDR_W-1:2];
    aligned     = (addr_i[1:0] == 2'b00);
    flag_page   = aligned && (addr_i[ADDR_W-1:10] == FLAG_PG);
    slot        = addr_i[7:2];
    cfg_hit_o   = aligned && (word_addr != '0) && (word_addr <= LAST_SRC);
    cfg_idx_o   = word_addr[IDX_W-1:0];
    num_hit_o   = flag_page && (slot == NUM_SLOT);
    bulk_hit_o  = flag_page && (slot < WORDS);
    bulk_word_o = slot[4:0];
    op_o        = bitop_e'(addr_i[9:8]);
  end
endmodule

// File: rtl/isrc_cfg_bank.sv
module isrc_cfg_bank
  import isrc_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_i,
  input  logic [IDX_W-1:0]         wr_idx_i,
  input  logic [31:0]              wdata_i,
  input  logic [IDX_W-1:0]         rd_idx_i,
  output logic [31:0]              rd_word_o,
  output logic [NUM_SRC:1][2:0]    mode_o,
  output logic [NUM_SRC:1]         deleg_o
);
  cfg_t [NUM_SRC:1] cfg_q;

  for (genvar i = 1; i <= NUM_SRC; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[i] <= '0;
      else if (we_i && wr_idx_i == IDX_W'(i)) cfg_q[i] <= cfg_pack(wdata_i);
    end
    assign mode_o[i]  = cfg_q[i].deleg ? 3'd0 : cfg_q[i].payload[2:0];
    assign deleg_o[i] = cfg_q[i].deleg;
  end

  always_comb begin
    rd_word_o = '0;
    for (int i = 1; i <= NUM_SRC; i++)
      if (rd_idx_i == IDX_W'(i)) rd_word_o = cfg_view(cfg_q[i]);
  end

  // R3: reserved codes never reach the stored mode
  reserved_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i && !wdata_i[DEL_BIT] && wdata_i[2:1] == 2'b01 && rd_idx_i == wr_idx_i
    |=> rd_word_o == 32'd0);
endmodule

// File: rtl/isrc_slice.sv
module isrc_slice
  import isrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,
  input  logic       deleg_i,
  input  logic       wire_i,
  input  logic       set_ip_i,
  input  logic       clr_ip_i,
  input  logic       set_ie_i,
  input  logic       clr_ie_i,
  input  logic       claim_i,
  output logic       pend_o,
  output logic       en_o
);
  logic in_q, pend_q, en_q;
  logic act, edge_m, lvl_m, det_m, inv;
  logic rect, rect_prev, edge_hit;
  logic pend_d, en_d;

  always_comb begin
    act       = !deleg_i && (mode_i != SM_OFF);
    edge_m    = act && mode_is_edge(mode_i);
    lvl_m     = act && mode_is_level(mode_i);
    det_m     = act && (mode_i == SM_DETACH);
    inv       = mode_inverts(mode_i);
    rect      = wire_i ^ inv;
    rect_prev = in_q ^ inv;
    edge_hit  = edge_m && rect && !rect_prev;
  end

  always_comb begin
    if (!act)       pend_d = 1'b0;
    else if (lvl_m) pend_d = rect;
    else            pend_d = edge_hit | set_ip_i | (pend_q & ~(clr_ip_i | claim_i));
    if (!act)          en_d = 1'b0;
    else if (set_ie_i) en_d = 1'b1;
    else if (clr_ie_i) en_d = 1'b0;
    else               en_d = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= 1'b0;
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      in_q   <= wire_i;
      pend_q <= pend_d;
      en_q   <= en_d;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;

  // R4
  idle_src_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> !pend_o && !en_o);
  // R6
  edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit && (clr_ip_i || claim_i) |=> pend_o);
  // R6
  claim_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_m || det_m) && claim_i && !edge_hit && !set_ip_i |=> !pend_o);
  // R7
  level_no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_m && set_ip_i && !rect |=> !pend_o);
  // R8
  detach_ignores_wire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    det_m && !set_ip_i && !pend_o |=> !pend_o);
endmodule

// File: rtl/isrc_frontend.sv
module isrc_frontend
  import isrc_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int ADDR_W  = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               claim_valid,
  input  logic [IDX_W-1:0]   claim_id,
  output logic [NUM_SRC-1:0] irq_pe
);
  localparam int NWORDS = (NUM_SRC + 32) / 32;
  localparam int FLAG_W = NWORDS * 32;

  logic                  cfg_hit, bulk_hit, num_hit;
  logic [IDX_W-1:0]      cfg_idx;
  logic [4:0]            bulk_word;
  bitop_e                op;
  logic [31:0]           cfg_rd;
  logic [NUM_SRC:1][2:0] mode;
  logic [NUM_SRC:1]      deleg;
  logic [FLAG_W-1:0]     pend_all, en_all;

  isrc_addr_dec #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .NWORDS(NWORDS)) u_dec (
    .addr_i      (reg_addr),
    .cfg_hit_o   (cfg_hit),
    .cfg_idx_o   (cfg_idx),
    .bulk_hit_o  (bulk_hit),
    .bulk_word_o (bulk_word),
    .num_hit_o   (num_hit),
    .op_o        (op)
  );

  isrc_cfg_bank #(.NUM_SRC(NUM_SRC)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (reg_we && cfg_hit),
    .wr_idx_i  (cfg_idx),
    .wdata_i   (reg_wdata),
    .rd_idx_i  (cfg_hit ? cfg_idx : '0),
    .rd_word_o (cfg_rd),
    .mode_o    (mode),
    .deleg_o   (deleg)
  );

  assign pend_all[0] = 1'b0;
  assign en_all[0]   = 1'b0;
  if (FLAG_W > NUM_SRC + 1) begin : g_pad
    assign pend_all[FLAG_W-1:NUM_SRC+1] = '0;
    assign en_all[FLAG_W-1:NUM_SRC+1]   = '0;
  end

  for (genvar i = 1; i <= NUM_SRC; i++) begin : g_src
    localparam int WI = i / 32;
    localparam int BI = i % 32;
    logic word_sel, num_sel, hit, claim_me;
    logic set_ip, clr_ip, set_ie, clr_ie;

    always_comb begin
      word_sel = reg_we && bulk_hit && (bulk_word == 5'(WI));
      num_sel  = reg_we && num_hit && (reg_wdata[IDX_W-1:0] == IDX_W'(i));
      hit      = (word_sel && reg_wdata[BI]) || num_sel;
      set_ip   = hit && (op == OP_SETIP);
      clr_ip   = hit && (op == OP_CLRIP);
      set_ie   = hit && (op == OP_SETIE);
      clr_ie   = hit && (op == OP_CLRIE);
      claim_me = claim_valid && (claim_id == IDX_W'(i));
    end

    isrc_slice u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_i   (mode[i]),
      .deleg_i  (deleg[i]),
      .wire_i   (src_in[i-1]),
      .set_ip_i (set_ip),
      .clr_ip_i (clr_ip),
      .set_ie_i (set_ie),
      .clr_ie_i (clr_ie),
      .claim_i  (claim_me),
      .pend_o   (pend_all[i]),
      .en_o     (en_all[i])
    );

    assign irq_pe[i-1] = pend_all[i] & en_all[i];

    // R4
    deleg_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      deleg[i] |=> !irq_pe[i-1]);
  end

  always_comb begin
    reg_rdata = '0;
    if (cfg_hit) begin
      reg_rdata = cfg_rd;
    end else if (bulk_hit) begin
      for (int w = 0; w < NWORDS; w++) begin
        if (bulk_word == 5'(w)) begin
          if (op == OP_SETIP)      reg_rdata = pend_all[w*32 +: 32];
          else if (op == OP_SETIE) reg_rdata = en_all[w*32 +: 32];
        end
      end
    end
  end

  // R9
  one_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_hit, bulk_hit, num_hit}));
  // R9
  clear_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bulk_hit && (op == OP_CLRIP || op == OP_CLRIE) |-> reg_rdata == 32'd0);
endmodule

// File: tb/tb_isrc_frontend.sv
module tb_isrc_frontend;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = CLK_PERIOD / 4;
  localparam int NSRC       = 40;
  localparam int AW         = 14;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_in = '0;
  logic            reg_we = 1'b0;
  logic [AW-1:0]   reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            claim_valid = 1'b0;
  logic [9:0]      claim_id = '0;
  logic [NSRC-1:0] irq_pe;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    bit          is_irq;
    logic [AW-1:0] addr;
    logic [63:0] mask;
    logic [63:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  isrc_frontend #(.NUM_SRC(NSRC), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .claim_valid(claim_valid), .claim_id(claim_id), .irq_pe(irq_pe)
  );

  // monitor: compares one queued expectation per falling edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      logic [63:0] act;
      it  = sbq.pop_front();
      act = it.is_irq ? 64'(irq_pe) : {32'd0, reg_rdata};
      total++;
      if ((act & it.mask) !== it.exp) begin
        bad++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr,
                 act & it.mask, it.exp);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(posedge clk); #Q;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #Q;
    reg_we = 1'b0;
  endtask

  task automatic chk_rd(input logic [AW-1:0] a, input logic [31:0] m,
                        input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #Q;
    reg_addr = a;
    it.is_irq = 1'b0; it.addr = a; it.mask = {32'd0, m}; it.exp = {32'd0, e}; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic chk_irq(input logic [63:0] m, input logic [63:0] e, input string tag);
    item_t it;
    @(posedge clk); #Q;
    it.is_irq = 1'b1; it.addr = '0; it.mask = m; it.exp = e; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic set_src(input int n, input logic v);
    @(posedge clk); #Q;
    src_in[n-1] = v;
  endtask

  task automatic pulse_claim(input int n);
    @(posedge clk); #Q;
    claim_valid = 1'b1; claim_id = 10'(n);
    @(posedge clk); #Q;
    claim_valid = 1'b0;
  endtask

  function automatic logic [AW-1:0] cfg_at(input int n);
    return AW'(4 * n);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #Q rst_n = 1'b1;

    // R1 reset state
    chk_rd(cfg_at(1), 32'hFFFF_FFFF, 32'h0, "R1 cfg");
    chk_rd(14'h1C00, 32'hFFFF_FFFF, 32'h0, "R1 pending");
    chk_rd(14'h1E00, 32'hFFFF_FFFF, 32'h0, "R1 enable");
    chk_irq('1, 64'h0, "R1 irq");

    // R2 mode readback
    wr(cfg_at(3), 32'hFFFF_F004);
    chk_rd(cfg_at(3), 32'hFFFF_FFFF, 32'h4, "R2 rise readback");
    // R3 reserved codes
    wr(cfg_at(4), 32'h2);
    chk_rd(cfg_at(4), 32'hFFFF_FFFF, 32'h0, "R3 code2");
    wr(cfg_at(4), 32'h3);
    chk_rd(cfg_at(4), 32'hFFFF_FFFF, 32'h0, "R3 code3");
    // R4 delegate
    wr(cfg_at(5), 32'h0000_16A5);
    chk_rd(cfg_at(5), 32'hFFFF_FFFF, 32'h6A5, "R4 deleg readback");
    wr(14'h1CDC, 32'd5);
    wr(14'h1EDC, 32'd5);
    chk_rd(14'h1C00, 32'h20, 32'h0, "R4 deleg pending");
    chk_rd(14'h1E00, 32'h20, 32'h0, "R4 deleg enable");
    wr(14'h1C00, 32'h40);
    chk_rd(14'h1C00, 32'h40, 32'h0, "R4 inactive pending");
    // R3 source 0, R10 out-of-range number
    wr(14'h1C00, 32'h1);
    chk_rd(14'h1C00, 32'h1, 32'h0, "R3 source0");
    wr(14'h1EDC, 32'd41);
    wr(14'h1EDC, 32'd0);
    chk_rd(14'h1E04, 32'hFFFF_FFFF, 32'h0, "R10 bad number");

    // R5 rising edge
    wr(14'h1EDC, 32'd3);
    chk_rd(14'h1E00, 32'h8, 32'h8, "R10 setie num");
    set_src(3, 1'b1);
    chk_rd(14'h1C00, 32'h8, 32'h8, "R5 rise sets");
    chk_irq(64'h4, 64'h4, "R11 irq src3");
    set_src(3, 1'b0);
    chk_rd(14'h1C00, 32'h8, 32'h8, "R5 holds after fall");
    wr(14'h1DDC, 32'd3);
    chk_rd(14'h1C00, 32'h8, 32'h0, "R10 clrip num");
    // R6 edge beats claim, then plain claim
    @(posedge clk); #Q;
    claim_valid = 1'b1; claim_id = 10'd3; src_in[2] = 1'b1;
    @(posedge clk); #Q;
    claim_valid = 1'b0;
    chk_rd(14'h1C00, 32'h8, 32'h8, "R6 edge wins claim");
    pulse_claim(3);
    chk_rd(14'h1C00, 32'h8, 32'h0, "R6 claim clears");

    // R5 falling edge
    set_src(7, 1'b1);
    wr(cfg_at(7), 32'h5);
    chk_rd(14'h1C00, 32'h80, 32'h0, "R5 no fall yet");
    set_src(7, 1'b0);
    chk_rd(14'h1C00, 32'h80, 32'h80, "R5 fall sets");
    set_src(7, 1'b1);
    chk_rd(14'h1C00, 32'h80, 32'h80, "R5 fall holds");
    pulse_claim(7);
    chk_rd(14'h1C00, 32'h80, 32'h0, "R6 claim fall");

    // R7 level high
    wr(cfg_at(10), 32'h6);
    wr(14'h1E00, 32'h400);
    chk_rd(14'h1E00, 32'h408, 32'h408, "R9 bulk setie");
    set_src(10, 1'b1);
    chk_rd(14'h1C00, 32'h400, 32'h400, "R7 high follows");
    chk_irq(64'h200, 64'h200, "R11 irq src10");
    wr(14'h1DDC, 32'd10);
    chk_rd(14'h1C00, 32'h400, 32'h400, "R7 clear ignored");
    set_src(10, 1'b0);
    chk_rd(14'h1C00, 32'h400, 32'h0, "R7 high drops");
    wr(14'h1CDC, 32'd10);
    chk_rd(14'h1C00, 32'h400, 32'h0, "R7 set ignored");
    // R7 level low
    wr(cfg_at(11), 32'h7);
    chk_rd(14'h1C00, 32'h800, 32'h800, "R7 low inverted");
    set_src(11, 1'b1);
    chk_rd(14'h1C00, 32'h800, 32'h0, "R7 low drops");

    // R8 detached
    wr(cfg_at(35), 32'h1);
    set_src(35, 1'b1);
    chk_rd(14'h1C04, 32'h8, 32'h0, "R8 wire ignored");
    set_src(35, 1'b0);
    wr(14'h1C04, 32'h8);
    chk_rd(14'h1C04, 32'h8, 32'h8, "R8 sw set");
    wr(14'h1EDC, 32'd35);
    chk_rd(14'h1E04, 32'h8, 32'h8, "R9 enable word1");
    chk_irq(64'h4_0000_0000, 64'h4_0000_0000, "R11 irq src35");
    wr(14'h1D04, 32'h8);
    chk_rd(14'h1C04, 32'h8, 32'h0, "R8 bulk clear");

    // R9 zeros have no effect, clear windows read 0
    wr(14'h1CDC, 32'd3);
    wr(14'h1D00, 32'hFFFF_FFF7);
    chk_rd(14'h1C00, 32'h8, 32'h8, "R9 zeros keep");
    chk_rd(14'h1D00, 32'hFFFF_FFFF, 32'h0, "R9 clrip reads 0");
    wr(14'h1F00, 32'hFFFF_FFFF);
    chk_rd(14'h1E00, 32'hFFFF_FFFF, 32'h0, "R9 bulk clrie");
    chk_irq(64'h4, 64'h0, "R11 disabled masks");
    // R4 delegating clears state
    wr(cfg_at(3), 32'h400);
    chk_rd(cfg_at(3), 32'hFFFF_FFFF, 32'h400, "R4 deleg idx0");
    chk_rd(14'h1C00, 32'h8, 32'h0, "R4 deleg clears pending");

    repeat (3) @(posedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule